// File: doc/BRIEF.md
# Lane-Seeded Additive Scrambler and Descrambler

This block holds both directions of one serial lane's scrambling stage. On the transmit side it XORs each outgoing data byte with eight successive output bits of a 16-bit linear feedback shift register. On the receive side an identical register and XOR strip the pattern off again. Every beat is one byte wide and carries a flag that marks it as a control character. Control characters cross the block untouched.

The two ends stay in step through the lane's comma control character. Whenever a comma passes through either direction, that direction's register reloads a seed built from the static lane number. Each direction has its own enable, so scrambling can be turned on for transmit only or for receive only. A disabled direction passes its data through unchanged but keeps its register stepping. Each output is registered, and the valid and control flags travel with the data.

Top module: `lane_scrambler`

## Requirements
- R1: A synchronous active-high reset clears both output valids and the output control flags, and loads each register with the seed, so the first data byte after reset is scrambled with the seed's pattern.
- R2: One register step outputs bit 15 and then shifts left by one. When the bit shifted out was 1, mask 16'h0039 (taps of x^16+x^5+x^4+x^3+1) is XORed into the shifted value. Bit i of a byte (LSB first, i = 0..7) uses the output of step i+1, and eight steps are taken within one cycle.
- R3: On the transmit side, a valid data byte (control flag 0) is XORed with its eight register outputs when the transmit enable is 1, and the register advances eight steps.
- R4: A valid control byte (control flag 1) other than the comma passes through unchanged with its control flag set, and the register does not advance. This holds in both directions.
- R5: A valid control byte equal to 8'hBC (comma) passes through unchanged and reloads that direction's register with 16'hFFFF XOR the 4-bit lane number zero-extended. A later change of lane number takes effect only at the next comma.
- R6: When the transmit enable is 0, transmit data passes through unchanged. The receive direction is not affected.
- R7: When the receive enable is 0, receive data passes through unchanged. When the receive enable is 1, receive data bytes are XORed with the receive register outputs.
- R8: Each register advances on every valid data byte, whether or not its enable is set.
- R9: Outputs appear exactly one cycle after the input beat. While valid is low the output valid is low and the register holds.
- R10: A transmit stream fed into the receive side with the same lane number and the same comma alignment comes out of the receive side equal to the original bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_id | input | LANE_W | Static lane number used in the seed |
| tx_scr_en | input | 1 | Transmit scrambling enable |
| tx_valid | input | 1 | Transmit input beat valid |
| tx_k | input | 1 | Transmit input control flag |
| tx_data | input | DW | Transmit input byte |
| tx_out_valid | output | 1 | Transmit output valid |
| tx_out_k | output | 1 | Transmit output control flag |
| tx_out_data | output | DW | Transmit output byte |
| rx_dscr_en | input | 1 | Receive descrambling enable |
| rx_valid | input | 1 | Receive input beat valid |
| rx_k | input | 1 | Receive input control flag |
| rx_data | input | DW | Receive input byte |
| rx_out_valid | output | 1 | Receive output valid |
| rx_out_k | output | 1 | Receive output control flag |
| rx_out_data | output | DW | Receive output byte |

## Verification
The bench builds the block with its default parameters: an 8-bit beat, a 4-bit lane number and the comma code 8'hBC. With these values the real polynomial and byte-parallel stepping are reached. The bench drives two different lane numbers, 5 and 9, so the seed derivation and the deferral of a lane change until the next comma are both checked. Because the 4-bit lane width is small, any seed stays far from zero, and the register can never lock up.

// File: rtl/lane_scrambler.sv
module lane_scrambler #(
  parameter int DW = 8,
  parameter int LANE_W = 4,
  parameter logic [DW-1:0] COM_CHAR = 8'hBC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] lane_id,
  input  logic              tx_scr_en,
  input  logic              tx_valid,
  input  logic              tx_k,
  input  logic [DW-1:0]     tx_data,
  output logic              tx_out_valid,
  output logic              tx_out_k,
  output logic [DW-1:0]     tx_out_data,
  input  logic              rx_dscr_en,
  input  logic              rx_valid,
  input  logic              rx_k,
  input  logic [DW-1:0]     rx_data,
  output logic              rx_out_valid,
  output logic              rx_out_k,
  output logic [DW-1:0]     rx_out_data
);

  localparam int LW = 16;
  localparam logic [LW-1:0] TAPS = 16'h0039;

  function automatic logic [LW+DW-1:0] advance(input logic [LW-1:0] s);
    logic [LW-1:0] t;
    logic [DW-1:0] m;
    t = s;
    m = '0;
    for (int i = 0; i < DW; i++) begin
      m[i] = t[LW-1];
      t = {t[LW-2:0], 1'b0} ^ (t[LW-1] ? TAPS : '0);
    end
    return {t, m};
  endfunction

  logic [LW-1:0] seed;
  assign seed = {LW{1'b1}} ^ {{(LW-LANE_W){1'b0}}, lane_id};

  logic [LW-1:0] tx_lfsr, tx_nxt, rx_lfsr, rx_nxt;
  logic [DW-1:0] tx_mask, rx_mask;
  logic tx_com, rx_com;

  assign {tx_nxt, tx_mask} = advance(tx_lfsr);
  assign {rx_nxt, rx_mask} = advance(rx_lfsr);
  assign tx_com = tx_k && (tx_data == COM_CHAR);
  assign rx_com = rx_k && (rx_data == COM_CHAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_lfsr      <= seed;
      tx_out_valid <= 1'b0;
      tx_out_k     <= 1'b0;
      tx_out_data  <= '0;
    end else begin
      tx_out_valid <= tx_valid;
      if (tx_valid) begin
        tx_out_k    <= tx_k;
        tx_out_data <= (tx_k || !tx_scr_en) ? tx_data : tx_data ^ tx_mask;
        if (tx_com) tx_lfsr <= seed;
        else if (!tx_k) tx_lfsr <= tx_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_lfsr      <= seed;
      rx_out_valid <= 1'b0;
      rx_out_k     <= 1'b0;
      rx_out_data  <= '0;
    end else begin
      rx_out_valid <= rx_valid;
      if (rx_valid) begin
        rx_out_k    <= rx_k;
        rx_out_data <= (rx_k || !rx_dscr_en) ? rx_data : rx_data ^ rx_mask;
        if (rx_com) rx_lfsr <= seed;
        else if (!rx_k) rx_lfsr <= rx_nxt;
      end
    end
  end

  AST_TX_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst) tx_valid |=> tx_out_valid); // R9
  AST_TX_IDLE: assert property (@(posedge clk) disable iff (rst) !tx_valid |=> !tx_out_valid && $stable(tx_lfsr)); // R9
  AST_TX_CTRL_PASS: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_k |=> tx_out_k && tx_out_data == $past(tx_data)); // R4
  AST_TX_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_k && tx_data != COM_CHAR |=> $stable(tx_lfsr)); // R4
  AST_TX_COM_SEED: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_k && tx_data == COM_CHAR |=> tx_lfsr == $past(seed)); // R5
  AST_TX_BYPASS: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_scr_en |=> tx_out_data == $past(tx_data)); // R6
  AST_TX_DATA_STEP: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_k |=> tx_lfsr != $past(tx_lfsr)); // R8
  AST_RX_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst) rx_valid |=> rx_out_valid); // R9
  AST_RX_COM_SEED: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_k && rx_data == COM_CHAR |=> rx_lfsr == $past(seed)); // R5
  AST_RX_BYPASS: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_dscr_en |=> rx_out_data == $past(rx_data)); // R7
  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst) tx_lfsr != '0 && rx_lfsr != '0); // R2

endmodule

// File: tb/lane_scrambler_test.sv
module lane_scrambler_test;
  logic clk = 0, rst = 1;
  logic [3:0] lane_id = 4'd5;
  logic tx_scr_en = 1, tx_valid = 0, tx_k = 0;
  logic [7:0] tx_data = 0;
  logic rx_dscr_en = 1, rx_valid = 0, rx_k = 0;
  logic [7:0] rx_data = 0;
  logic tx_out_valid, tx_out_k, rx_out_valid, rx_out_k;
  logic [7:0] tx_out_data, rx_out_data;
  int total = 0, fails = 0;
  logic [15:0] m_tx, m_rx;
  logic [7:0] cap;

  always #2 clk = ~clk;

  lane_scrambler uut (.*);

  function automatic logic [15:0] m_seed(input logic [3:0] ln);
    return 16'hFFFF ^ {12'd0, ln};
  endfunction

  function automatic logic [23:0] m_steps(input logic [15:0] s);
    logic [7:0] m;
    logic fb;
    for (int b = 0; b < 8; b++) begin
      fb = s[15];
      m[b] = fb;
      s = s << 1;
      if (fb) begin s[0] ^= 1'b1; s[3] ^= 1'b1; s[4] ^= 1'b1; s[5] ^= 1'b1; end
    end
    return {s, m};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tx_beat(input logic k, input logic [7:0] d, input string req, output logic [7:0] got);
    logic [23:0] st;
    logic [7:0] exp;
    st = m_steps(m_tx);
    exp = (k || !tx_scr_en) ? d : d ^ st[7:0];
    tx_valid = 1; tx_k = k; tx_data = d;
    @(negedge clk);
    check(req, {tx_out_valid, tx_out_k, tx_out_data}, {1'b1, k, exp});
    got = tx_out_data;
    if (k && d == 8'hBC) m_tx = m_seed(lane_id);
    else if (!k) m_tx = st[23:8];
    tx_valid = 0;
  endtask

  task automatic rx_beat(input logic k, input logic [7:0] d, input string req, output logic [7:0] got);
    logic [23:0] st;
    logic [7:0] exp;
    st = m_steps(m_rx);
    exp = (k || !rx_dscr_en) ? d : d ^ st[7:0];
    rx_valid = 1; rx_k = k; rx_data = d;
    @(negedge clk);
    check(req, {rx_out_valid, rx_out_k, rx_out_data}, {1'b1, k, exp});
    got = rx_out_data;
    if (k && d == 8'hBC) m_rx = m_seed(lane_id);
    else if (!k) m_rx = st[23:8];
    rx_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 tx valid", tx_out_valid, 0);
    check("R1 rx valid", rx_out_valid, 0);
    check("R1 k flags", {tx_out_k, rx_out_k}, 0);
    tx_beat(0, 8'h00, "R1 first byte uses seed", cap);
    check("R1 seed pattern", cap, 8'hFF);
  endtask

  task automatic t_stream;
    logic [7:0] pat [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    foreach (pat[i]) tx_beat(0, pat[i], "R2 R3 data scramble", cap);
  endtask

  task automatic t_ctrl;
    tx_beat(1, 8'h1C, "R4 tx control pass", cap);
    tx_beat(1, 8'hF7, "R4 tx control pass", cap);
    tx_beat(0, 8'h55, "R4 no advance on control", cap);
    rx_beat(1, 8'h7C, "R4 rx control pass", cap);
    rx_beat(0, 8'h12, "R4 rx no advance", cap);
  endtask

  task automatic t_com;
    tx_beat(1, 8'hBC, "R5 comma passes", cap);
    tx_beat(0, 8'h00, "R5 reload to seed", cap);
    check("R5 lane 5 seed pattern", cap, m_steps(m_seed(4'd5))[7:0]);
    lane_id = 4'd9;
    tx_beat(0, 8'h00, "R5 lane change deferred", cap);
    tx_beat(1, 8'hBC, "R5 comma lane 9", cap);
    tx_beat(0, 8'h00, "R5 lane 9 seed", cap);
    check("R5 lane 9 seed pattern", cap, m_steps(m_seed(4'd9))[7:0]);
  endtask

  task automatic t_bypass;
    tx_scr_en = 0;
    tx_beat(0, 8'h6B, "R6 tx bypass", cap);
    check("R6 bypass unchanged", cap, 8'h6B);
    tx_beat(0, 8'hD2, "R8 advance in bypass", cap);
    rx_beat(0, 8'h40, "R6 rx unaffected", cap);
    tx_scr_en = 1;
    tx_beat(0, 8'h00, "R8 state advanced", cap);
    rx_dscr_en = 0;
    rx_beat(0, 8'h99, "R7 rx bypass", cap);
    check("R7 rx unchanged", cap, 8'h99);
    rx_beat(0, 8'h11, "R8 rx advance in bypass", cap);
    rx_dscr_en = 1;
    rx_beat(0, 8'h00, "R7 R8 rx descramble resumes", cap);
  endtask

  task automatic t_idle;
    tx_valid = 0; rx_valid = 0;
    repeat (3) begin
      @(negedge clk);
      check("R9 idle valid low", {tx_out_valid, rx_out_valid}, 0);
    end
    tx_beat(0, 8'h77, "R9 state held over idle", cap);
  endtask

  task automatic t_loop;
    logic [7:0] orig [6] = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB};
    logic [7:0] back;
    tx_beat(1, 8'hBC, "R10 tx comma", cap);
    rx_beat(1, 8'hBC, "R10 rx comma", back);
    foreach (orig[i]) begin
      tx_beat(0, orig[i], "R10 tx", cap);
      rx_beat(0, cap, "R10 rx", back);
      check("R10 recovered", back, orig[i]);
    end
  endtask

  initial begin
    #800000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    m_tx = m_seed(lane_id);
    m_rx = m_seed(lane_id);
    t_reset();
    t_stream();
    t_ctrl();
    t_com();
    t_bypass();
    t_idle();
    t_loop();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule